// File: doc/BRIEF.md
# Programmable Pulse-Swallow Feedback Divider

This block is the feedback divider of a frequency synthesizer that works on a 6 MHz channel grid. It divides a fast input clock by a programmable modulus M = P + S. P is a power-of-two base modulus, picked by a four-line thermometer band select. S is a swallow count taken from a control word. The synthesized frequency is M × 6 MHz. The five bands therefore cover 48–90, 96–186, 192–378, 384–762 and 768–840 MHz.

The divider is fully synchronous. A single down counter is reloaded with M − 1 each time it reaches zero, and one output pulse, one input cycle wide, marks every reload. The band select and the swallow word are read only at the reload instant. A setting changed partway through a division cycle therefore takes effect from the next cycle on, and the current cycle is never cut short or stretched. In every band except the top one, S may range from 0 to P − 1. In the top band (P = 128), S stops at 12. A swallow word above the band limit is clamped to that limit.

Top module: `pswdiv_top`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `div_pulse` is low after that edge. At the first rising edge with `rst_n` high, a reload takes place and `div_pulse` goes high.
- R2: Every high phase of `div_pulse` lasts exactly one `clk` cycle.
- R3: `band_sel` bits [3],[2],[1],[0] are the band lines for the 8, 16, 32 and 64 bands, each meaning "base below the next power". The code 1111 gives P = 8, 0111 gives P = 16, 0011 gives P = 32, 0001 gives P = 64 and 0000 gives P = 128. With S = 0, the pulse period equals P.
- R4: A code that is not a thermometer code resolves to the lowest band whose line is high. For example, 1010 gives P = 8, 0101 gives P = 16 and 0010 gives P = 32.
- R5: For P ≤ 64 and 0 ≤ S ≤ P − 1, consecutive rising edges of `div_pulse` are exactly P + S `clk` cycles apart. S is the unsigned value of `swallow`.
- R6: In the P = 128 band, S is limited to 0..12. The period for S ≤ 12 is 128 + S, and for any larger S it is 140.
- R7: In the bands P ≤ 64, a `swallow` value above P − 1 is clamped to P − 1, which gives a period of 2P − 1.
- R8: `band_sel` and `swallow` are sampled only at the edge that raises `div_pulse`. A change made during a division cycle leaves that cycle's length unchanged and sets the length of the following cycle.
- R9: Asserting `rst_n` low in the middle of a division cycle stops the pulses. After release, the divider restarts as in R1 with the settings present at the release edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| band_sel | input | 4 | Thermometer band select; bit 3 is the lowest band's line |
| swallow | input | 7 | Swallow count S, unsigned |
| div_pulse | output | 1 | One-cycle pulse per M input cycles |

## Verification
The reload edge has to do two things in the same cycle: end the current division cycle by pulsing, and capture the settings that fix the next cycle. The bench provokes this overlap by changing the band and swallow word a few cycles into a running division cycle, and also right after a pulse. It then judges two periods separately: the cycle that was running must keep its old length, and the following cycle must take the new length. A reset dropped in mid-cycle provokes the overlap between a restart and a reload that was pending. There, the bench checks that the pulse goes away during reset and that a fresh pulse comes at the release edge.

// File: rtl/pswdiv_pkg.sv
// Package: pswdiv_pkg
// Shared defaults for the pulse-swallow divider. Holds the band geometry:
// the smallest base modulus as a power of two, the number of bands, and
// the swallow limit of the top band.
package pswdiv_pkg;
    localparam int DEF_BASE_LOG2 = 3;   // smallest base modulus is 2**3 = 8
    localparam int DEF_NUM_BANDS = 5;   // bases 8, 16, 32, 64, 128
    localparam int DEF_TOP_SMAX  = 12;  // top band swallow ceiling
endpackage

// File: rtl/pswdiv_band_dec.sv
// Module: pswdiv_band_dec
// Turns the thermometer band lines into a base modulus and the largest
// swallow count allowed in that band.
// Assumes: band_sel[SEL_W-1] belongs to the lowest band. A line that is
// high means "base is below the next band". A code that is not a
// thermometer code resolves to the lowest band whose line is high.
module pswdiv_band_dec #(
    parameter int BASE_LOG2 = pswdiv_pkg::DEF_BASE_LOG2,
    parameter int NUM_BANDS = pswdiv_pkg::DEF_NUM_BANDS,
    parameter int TOP_SMAX  = pswdiv_pkg::DEF_TOP_SMAX,
    parameter int M_W       = BASE_LOG2 + NUM_BANDS
) (
    input  logic [NUM_BANDS-2:0] band_sel,
    output logic [M_W-1:0]       p_val,
    output logic [M_W-1:0]       s_max
);
    localparam int SEL_W = NUM_BANDS - 1;
    localparam int IDX_W = $clog2(NUM_BANDS);

    logic [M_W-1:0]   cand_p    [NUM_BANDS];
    logic [M_W-1:0]   cand_smax [NUM_BANDS];
    logic [IDX_W-1:0] band_idx;

    // Per-band constants: base modulus and swallow ceiling.
    for (genvar k = 0; k < NUM_BANDS; k++) begin : g_band
        assign cand_p[k] = M_W'(1) << (BASE_LOG2 + k);
        if (k == NUM_BANDS - 1) begin : g_top
            assign cand_smax[k] = M_W'(TOP_SMAX);
        end else begin : g_low
            assign cand_smax[k] = M_W'((1 << (BASE_LOG2 + k)) - 1);
        end
    end

    // Priority pick: the lowest band whose line is high, else the top band.
    always_comb begin
        band_idx = IDX_W'(NUM_BANDS - 1);
        for (int k = NUM_BANDS - 2; k >= 0; k--) begin
            if (band_sel[SEL_W-1-k]) band_idx = IDX_W'(k);
        end
    end

    // Output mux for the chosen band.
    always_comb begin
        p_val = cand_p[band_idx];
        s_max = cand_smax[band_idx];
    end
endmodule

// File: rtl/pswdiv_mod_calc.sv
// Module: pswdiv_mod_calc
// Clamps the swallow word to the band ceiling and forms the reload value
// M - 1 = P + S - 1 for the down counter.
// Assumes: p_val is a power of two of at least 2, and s_max < p_val.
module pswdiv_mod_calc #(
    parameter int S_W = 7,
    parameter int M_W = 8
) (
    input  logic [S_W-1:0] swallow,
    input  logic [M_W-1:0] p_val,
    input  logic [M_W-1:0] s_max,
    output logic [M_W-1:0] reload_val
);
    logic [M_W-1:0] s_wide;
    logic [M_W-1:0] s_eff;

    // Bring the swallow word to counter width.
    assign s_wide = M_W'(swallow);

    // Clamp S to the band ceiling, then form P + S - 1.
    always_comb begin
        s_eff      = (s_wide > s_max) ? s_max : s_wide;
        reload_val = p_val + s_eff - M_W'(1);
    end
endmodule

// File: rtl/pswdiv_counter.sv
// Module: pswdiv_counter
// Down counter that reloads from load_val whenever it sits at zero, and
// raises a registered one-cycle pulse on each reload.
// Assumes: load_val is at least 1, so pulses never touch. The caller
// presents load_val every cycle, but only the reload edge samples it.
module pswdiv_counter #(
    parameter int M_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [M_W-1:0] load_val,
    output logic           pulse
);
    logic [M_W-1:0] cnt_q;
    logic           at_zero;

    // Terminal detect on the count.
    assign at_zero = (cnt_q == '0);

    // Count down, reload at zero, flag each reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pulse <= 1'b0;
        end else if (at_zero) begin
            cnt_q <= load_val;
            pulse <= 1'b1;
        end else begin
            cnt_q <= cnt_q - M_W'(1);
            pulse <= 1'b0;
        end
    end

    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse); // R2
    AST_RELOAD_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        at_zero |=> pulse); // R1
    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !at_zero |=> (cnt_q == $past(cnt_q) - M_W'(1)) && !pulse); // R5
endmodule

// File: rtl/pswdiv_top.sv
// Module: pswdiv_top
// Synchronous pulse-swallow feedback divider: divides clk by P + S, where
// P comes from the thermometer band select and S from the swallow word.
// Assumes: a single clock domain, and a reset that is synchronous and
// active low. Settings are sampled at the reload edge only.
module pswdiv_top #(
    parameter int BASE_LOG2 = pswdiv_pkg::DEF_BASE_LOG2,
    parameter int NUM_BANDS = pswdiv_pkg::DEF_NUM_BANDS,
    parameter int TOP_SMAX  = pswdiv_pkg::DEF_TOP_SMAX
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANDS-2:0] band_sel,
    input  logic [BASE_LOG2+NUM_BANDS-2:0] swallow,
    output logic                 div_pulse
);
    localparam int TOP_LOG2 = BASE_LOG2 + NUM_BANDS - 1;
    localparam int S_W      = TOP_LOG2;
    localparam int M_W      = TOP_LOG2 + 1;

    logic [M_W-1:0] p_val;
    logic [M_W-1:0] s_max;
    logic [M_W-1:0] reload_val;

    // Band lines to base modulus and swallow ceiling.
    pswdiv_band_dec #(
        .BASE_LOG2 (BASE_LOG2),
        .NUM_BANDS (NUM_BANDS),
        .TOP_SMAX  (TOP_SMAX),
        .M_W       (M_W)
    ) u_band (
        .band_sel (band_sel),
        .p_val    (p_val),
        .s_max    (s_max)
    );

    // Clamp the swallow count and form the reload value.
    pswdiv_mod_calc #(
        .S_W (S_W),
        .M_W (M_W)
    ) u_mod (
        .swallow    (swallow),
        .p_val      (p_val),
        .s_max      (s_max),
        .reload_val (reload_val)
    );

    // Reloading down counter and output pulse.
    pswdiv_counter #(
        .M_W (M_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_val (reload_val),
        .pulse    (div_pulse)
    );

    AST_BASE_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(p_val) == 1); // R3
    AST_RELOAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_val >= p_val - M_W'(1)) && (reload_val - (p_val - M_W'(1)) <= s_max)); // R7
    AST_TOP_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (band_sel == '0) |-> (reload_val <= M_W'((1 << TOP_LOG2) + TOP_SMAX - 1))); // R6
endmodule

// File: tb/pswdiv_top_tb_top.sv
`timescale 1ns/1ps
module pswdiv_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] band_sel = 4'b1111;
    logic [6:0] swallow = '0;
    logic       div_pulse;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_n = 0;
    bit got_pulse = 0;
    bit prev_pulse = 0;

    pswdiv_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .band_sel  (band_sel),
        .swallow   (swallow),
        .div_pulse (div_pulse)
    );

    always #2.5 clk = ~clk;

    // Expected period from the requirements.
    function automatic int model_m(input logic [3:0] b, input logic [6:0] s);
        int p, smax, se;
        if (b[3]) p = 8;
        else if (b[2]) p = 16;
        else if (b[1]) p = 32;
        else if (b[0]) p = 64;
        else p = 128;
        smax = (p == 128) ? 12 : p - 1;
        se = (int'(s) > smax) ? smax : int'(s);
        return p + se;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: sample after the edge, track pulse spacing and width.
    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
        if (div_pulse) begin
            check(!prev_pulse, "R2", int'(prev_pulse), 0);
            last_n = cyc;
            cyc = 0;
            got_pulse = 1;
        end
        prev_pulse = div_pulse;
    endtask

    task automatic wait_pulse(output int n);
        int guard = 0;
        got_pulse = 0;
        while (!got_pulse && guard < 400) begin
            tick();
            guard++;
        end
        if (!got_pulse) check(0, "watchdog_pulse", guard, 0);
        n = last_n;
    endtask

    // Apply settings mid-period, let one reload take them, measure next period.
    task automatic run_case(input logic [3:0] b, input logic [6:0] s, input string tag);
        int n;
        band_sel = b;
        swallow = s;
        wait_pulse(n);
        wait_pulse(n);
        check(n == model_m(b, s), tag, n, model_m(b, s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int ma;
        void'($urandom(32'h1A2B3C4D));
        // R1: reset holds the pulse low, release gives a pulse at once.
        rst_n = 1'b0;
        repeat (3) begin
            tick();
            check(div_pulse == 1'b0, "R1", int'(div_pulse), 0);
        end
        rst_n = 1'b1;
        tick();
        check(div_pulse == 1'b1, "R1", int'(div_pulse), 1);

        // R3: each thermometer code with S = 0.
        run_case(4'b1111, 7'd0, "R3");
        run_case(4'b0111, 7'd0, "R3");
        run_case(4'b0011, 7'd0, "R3");
        run_case(4'b0001, 7'd0, "R3");
        run_case(4'b0000, 7'd0, "R3");
        // R4: non-thermometer codes.
        run_case(4'b1010, 7'd0, "R4");
        run_case(4'b0101, 7'd0, "R4");
        run_case(4'b0010, 7'd3, "R4");
        // R5: in-range swallow counts, top of range.
        run_case(4'b1111, 7'd7, "R5");
        run_case(4'b0111, 7'd15, "R5");
        run_case(4'b0011, 7'd31, "R5");
        run_case(4'b0001, 7'd63, "R5");
        run_case(4'b0001, 7'd1, "R5");
        // R6: top band cap.
        run_case(4'b0000, 7'd12, "R6");
        run_case(4'b0000, 7'd13, "R6");
        run_case(4'b0000, 7'd127, "R6");
        // R7: clamp in lower bands.
        run_case(4'b1111, 7'd8, "R7");
        run_case(4'b0111, 7'd127, "R7");
        run_case(4'b0011, 7'd100, "R7");

        // R8: change mid-cycle; running cycle keeps old length.
        band_sel = 4'b0011; swallow = 7'd5;
        wait_pulse(n);
        ma = model_m(4'b0011, 7'd5);
        repeat (3) tick();
        band_sel = 4'b1111; swallow = 7'd2;
        wait_pulse(n);
        check(n == ma, "R8", n, ma);
        wait_pulse(n);
        check(n == model_m(4'b1111, 7'd2), "R8", n, model_m(4'b1111, 7'd2));

        // R9: reset in mid-cycle, restart on release.
        band_sel = 4'b0000; swallow = 7'd9;
        wait_pulse(n);
        repeat (20) tick();
        rst_n = 1'b0;
        repeat (2) begin
            tick();
            check(div_pulse == 1'b0, "R9", int'(div_pulse), 0);
        end
        band_sel = 4'b0111; swallow = 7'd4;
        rst_n = 1'b1;
        tick();
        check(div_pulse == 1'b1, "R9", int'(div_pulse), 1);
        wait_pulse(n);
        check(n == 20, "R9", n, 20);

        // Random mix, tag chosen by the case it lands in.
        for (int i = 0; i < 150; i++) begin
            logic [3:0] b;
            logic [6:0] s;
            int pick;
            int p;
            string tag;
            case ($urandom % 6)
                0: b = 4'b1111;
                1: b = 4'b0111;
                2: b = 4'b0011;
                3: b = 4'b0001;
                4: b = 4'b0000;
                default: b = 4'($urandom);
            endcase
            p = model_m(b, 7'd0);
            pick = $urandom % 4;
            if (pick == 0) s = 7'd0;
            else if (pick == 1) s = 7'((p == 128) ? 12 : p - 1);
            else if (pick == 2) s = 7'((p == 128) ? 13 : p);
            else s = 7'($urandom);
            if (p == 128) tag = "R6";
            else if (int'(s) > p - 1) tag = "R7";
            else tag = "R5";
            run_case(b, s, tag);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule